// File: doc/BRIEF.md
# Display Stage Power Sequencer

This block brings the four output stages of a display pipe up and down in a safe order. The stages are the pixel clock, the sync generator, the display-on signal and the backlight PWM. Software writes one-hot strobes to an enable port and to a disable port. The block turns these into per-stage enable levels. Each stage returns an acknowledge. The block filters that acknowledge through a programmable settle delay and reports the result as a per-stage status bit. That bit changes only once the stage has really started or stopped.

Requests that arrive out of order are not refused. They are parked and released once the stage they depend on is ready. A stage is enabled only after its predecessor reports up. The pixel clock and sync stages are switched off only after the stage that depends on them reports down. The display-on and PWM stages are switched off at once. A per-stage sticky timeout flag is raised when a stage's status fails to follow its enable within a bounded number of cycles. Software clears the flag by writing a one to its bit.

Top module: `disp_stage_seq`

## Requirements
- R1: After reset, every stage enable, status bit and timeout flag is 0.
- R2: The stage bit positions are: bit 0 pixel clock, bit 1 sync, bit 2 display-on, bit 3 PWM. An enable strobe for stage 0 sets its enable on the next edge. An enable strobe for stage i>0 sets the enable only if status i-1 is high. Otherwise the request is held pending and takes effect on the first edge that sees status i-1 high.
- R3: Enable strobes only add stages. Stages already enabled stay enabled. A strobe word of all zeros on the enable or disable port changes nothing.
- R4: A pending enable for stage i is discarded when a disable strobe for stage i-1 arrives before the enable is released.
- R5: A disable strobe clears the display-on (bit 2) or PWM (bit 3) enable on the next edge. A disable of sync waits until display-on status is low. A disable of the pixel clock waits until sync status is low.
- R6: A disable strobe and an enable strobe for the same stage in the same cycle act as a disable alone.
- R7: A status bit takes the acknowledge value on the S-th consecutive clock edge that samples the acknowledge different from the status. S is the stage's 4-bit settle field, from 1 to 15; a value of 0 acts as 1.
- R8: A stage's timeout flag is set on the edge that samples enable different from status for the TMO_CYCLES-th consecutive time (default 1000). The flag then stays set.
- R9: Writing a 1 to a bit of the clear port clears that timeout flag on the next edge, and zero bits leave the other flags alone. A cleared flag is not raised again until enable and status have matched and then disagreed for another full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_strobe | input | 4 | Write-one enable strobe per stage |
| dis_strobe | input | 4 | Write-one disable strobe per stage |
| tmo_clr | input | 4 | Write-one-to-clear for the timeout flags |
| settle_cfg | input | 16 | Settle delay per stage, 4 bits each, stage 0 in the low bits |
| stage_ack | input | 4 | Raw acknowledge from each stage |
| stage_en | output | 4 | Enable level driven to each stage |
| stage_sts | output | 4 | Settled status of each stage |
| tmo_flag | output | 4 | Sticky timeout flag per stage |

## Verification
The hardest cases to reach from the ports are the parked requests. These are an enable that sits pending behind a stage that is still settling, a pending enable that a predecessor disable must cancel, and a disable of the pixel clock held back behind a live sync stage. The stimulus table sends strobes deliberately out of order and lets a stage model return acknowledges with a delay. This puts each request into its parked state, and the bench checks the final enables and statuses. Directed tests then hold one acknowledge stuck low to step across the timeout boundary edge by edge, and use a non-default settle value to pin down the exact edge on which status changes.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    localparam int NSTAGE = 4;

    typedef enum logic [1:0] {
        ST_PCLK = 2'd0,
        ST_SYNC = 2'd1,
        ST_DISP = 2'd2,
        ST_PWM  = 2'd3
    } stage_e;

    typedef struct packed {
        logic on;
        logic pend_on;
        logic pend_off;
    } gate_t;

    // Stage whose status must be low before stage i may be switched off,
    // or -1 when stage i goes off at once.
    function automatic int dis_guard(input int i);
        return (i < NSTAGE - 2) ? i + 1 : -1;
    endfunction

endpackage

// File: rtl/dseq_gate.sv
module dseq_gate
    import dseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_req,
    input  logic dis_req,
    input  logic pred_up,
    input  logic pred_drop,
    input  logic guard_down,
    output logic en_out
);
    gate_t st, nxt;

    always_comb begin
        nxt = st;
        if (dis_req) begin
            nxt.pend_on = 1'b0;
            if (guard_down) begin
                nxt.on       = 1'b0;
                nxt.pend_off = 1'b0;
            end else begin
                nxt.pend_off = 1'b1;
            end
        end else if (en_req) begin
            nxt.pend_off = 1'b0;
            if (pred_up) begin
                nxt.on      = 1'b1;
                nxt.pend_on = 1'b0;
            end else if (!pred_drop) begin
                nxt.pend_on = 1'b1;
            end
        end else begin
            if (st.pend_on) begin
                if (pred_drop) begin
                    nxt.pend_on = 1'b0;
                end else if (pred_up) begin
                    nxt.on      = 1'b1;
                    nxt.pend_on = 1'b0;
                end
            end
            if (st.pend_off && guard_down) begin
                nxt.on       = 1'b0;
                nxt.pend_off = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    assign en_out = st.on;

    // R6
    pend_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(st.pend_on && st.pend_off));

endmodule

// File: rtl/dseq_settle.sv
module dseq_settle #(
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  logic [SET_W-1:0] cfg,
    output logic             sts
);
    logic [SET_W-1:0] cnt;
    logic [SET_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= 1'b0;
            cnt <= '0;
        end else if (ack == sts) begin
            cnt <= '0;
        end else if (cnt_inc >= {1'b0, cfg}) begin
            sts <= ack;
            cnt <= '0;
        end else begin
            cnt <= cnt_inc[SET_W-1:0];
        end
    end

    // R7
    sts_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts) |-> $past(ack));
    // R7
    sts_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sts) |-> !$past(ack));

endmodule

// File: rtl/dseq_watch.sv
module dseq_watch #(
    parameter int TMO_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sts,
    input  logic clr,
    output logic flag
);
    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYCLES);
    localparam logic [CW-1:0] FIRE  = CW'(TMO_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          mism;

    assign mism = (en != sts);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (!mism)            cnt <= '0;
            else if (cnt != LIMIT) cnt <= cnt + 1'b1;

            if (mism && cnt == FIRE) flag <= 1'b1;
            else if (clr)            flag <= 1'b0;
        end
    end

    // R8
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(mism));
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(clr) && !$past(mism)) |-> !flag);

endmodule

// File: rtl/disp_stage_seq.sv
module disp_stage_seq
    import dseq_pkg::*;
#(
    parameter int TMO_CYCLES = 1000,
    parameter int SET_W      = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSTAGE-1:0]        en_strobe,
    input  logic [NSTAGE-1:0]        dis_strobe,
    input  logic [NSTAGE-1:0]        tmo_clr,
    input  logic [NSTAGE*SET_W-1:0]  settle_cfg,
    input  logic [NSTAGE-1:0]        stage_ack,
    output logic [NSTAGE-1:0]        stage_en,
    output logic [NSTAGE-1:0]        stage_sts,
    output logic [NSTAGE-1:0]        tmo_flag
);
    logic [NSTAGE-1:0] pred_up, pred_drop, guard_down;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        localparam int G = dis_guard(i);

        if (i == 0) begin : g_first
            assign pred_up[i]   = 1'b1;
            assign pred_drop[i] = 1'b0;
        end else begin : g_chain
            assign pred_up[i]   = stage_sts[i-1];
            assign pred_drop[i] = dis_strobe[i-1];

            // R2
            en_order_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(stage_en[i]) |-> $past(stage_sts[i-1]));
        end

        if (G < 0) begin : g_free
            assign guard_down[i] = 1'b1;
        end else begin : g_guard
            assign guard_down[i] = !stage_sts[G];

            // R5
            dis_order_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(stage_en[i]) |-> !$past(stage_sts[G]));
        end

        dseq_gate u_gate (
            .clk        (clk),
            .rst        (rst),
            .en_req     (en_strobe[i]),
            .dis_req    (dis_strobe[i]),
            .pred_up    (pred_up[i]),
            .pred_drop  (pred_drop[i]),
            .guard_down (guard_down[i]),
            .en_out     (stage_en[i])
        );

        dseq_settle #(.SET_W(SET_W)) u_settle (
            .clk (clk),
            .rst (rst),
            .ack (stage_ack[i]),
            .cfg (settle_cfg[i*SET_W +: SET_W]),
            .sts (stage_sts[i])
        );

        dseq_watch #(.TMO_CYCLES(TMO_CYCLES)) u_watch (
            .clk  (clk),
            .rst  (rst),
            .en   (stage_en[i]),
            .sts  (stage_sts[i]),
            .clr  (tmo_clr[i]),
            .flag (tmo_flag[i])
        );
    end

endmodule

// File: tb/disp_stage_seq_test.sv
module disp_stage_seq_test;
    localparam int TMO = 1000;
    localparam int NV  = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  en_strobe = '0, dis_strobe = '0, tmo_clr = '0;
    logic [15:0] settle_cfg = 16'h3333;
    logic [3:0]  stage_ack;
    logic [3:0]  stage_en, stage_sts, tmo_flag;
    logic [3:0]  stuck = '0;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    disp_stage_seq #(.TMO_CYCLES(TMO), .SET_W(4)) uut (
        .clk(clk), .rst(rst), .en_strobe(en_strobe), .dis_strobe(dis_strobe),
        .tmo_clr(tmo_clr), .settle_cfg(settle_cfg), .stage_ack(stage_ack),
        .stage_en(stage_en), .stage_sts(stage_sts), .tmo_flag(tmo_flag));

    // stage model: acknowledge follows enable one cycle later unless stuck
    always_ff @(posedge clk) begin
        if (rst) stage_ack <= '0;
        else     stage_ack <= stage_en & ~stuck;
    end

    // {en_strobe, dis_strobe, expected enable, expected status}
    localparam logic [15:0] VEC [NV] = '{
        16'h1011, // R2 pixel clock up
        16'h4011, // R2 display before sync is held
        16'h2077, // R2 R3 sync up releases display, clock stays on
        16'h80FF, // R3 PWM added
        16'h01FF, // R5 clock off held while sync up
        16'h04BB, // R5 display off at once
        16'h0288, // R5 sync off, then parked clock off
        16'h0800, // R5 PWM off
        16'h0000, // R3 zero strobes change nothing
        16'h2000, // R2 sync without clock parks
        16'h0100, // R4 clock disable drops parked sync
        16'h1011, // R4 clock up, sync must stay off
        16'hF0FF, // R2 all at once: chain unwinds in order
        16'h0F00, // R5 all off: guarded stages wait
        16'h1100  // R6 enable and disable together
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [3:0] e, input logic [3:0] d, input logic [3:0] c);
        @(negedge clk);
        en_strobe = e; dis_strobe = d; tmo_clr = c;
        @(negedge clk);
        en_strobe = '0; dis_strobe = '0; tmo_clr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset", {stage_en, stage_sts, tmo_flag}, 12'h000);

        for (int v = 0; v < NV; v++) begin
            strobe(VEC[v][15:12], VEC[v][11:8], 4'h0);
            repeat (40) @(negedge clk);
            chk($sformatf("R2-table step %0d en", v), stage_en, VEC[v][7:4]);
            chk($sformatf("R2-table step %0d sts", v), stage_sts, VEC[v][3:0]);
        end
        chk("R8 no false timeout", tmo_flag, 4'h0);

        // R7 settle timing with S=5 on stage 0
        do_reset();
        settle_cfg = 16'h3335;
        strobe(4'h1, 4'h0, 4'h0);
        repeat (5) @(posedge clk);
        #1 chk("R7 sts before settle edge", stage_sts[0], 1'b0);
        @(posedge clk);
        #1 chk("R7 sts on settle edge", stage_sts[0], 1'b1);

        // R7 settle field of 0 behaves as 1
        do_reset();
        settle_cfg = 16'h3330;
        strobe(4'h1, 4'h0, 4'h0);
        repeat (1) @(posedge clk);
        #1 chk("R7 zero settle early", stage_sts[0], 1'b0);
        @(posedge clk);
        #1 chk("R7 zero settle edge", stage_sts[0], 1'b1);

        // R8 timeout boundary with stuck acknowledge
        do_reset();
        settle_cfg = 16'h3333;
        stuck = 4'h1;
        strobe(4'h1, 4'h0, 4'h0);
        repeat (TMO - 1) @(posedge clk);
        #1 chk("R8 flag before window", tmo_flag, 4'h0);
        @(posedge clk);
        #1 chk("R8 flag at window end", tmo_flag, 4'h1);
        repeat (20) @(negedge clk);
        chk("R8 flag sticky", tmo_flag, 4'h1);

        // R9 write-one-to-clear
        strobe(4'h0, 4'h0, 4'h2);
        chk("R9 zero bit leaves flag", tmo_flag, 4'h1);
        strobe(4'h0, 4'h0, 4'h1);
        chk("R9 clear", tmo_flag, 4'h0);
        repeat (50) @(negedge clk);
        chk("R9 no refire", tmo_flag, 4'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule